// File: doc/BRIEF.md
# Branch and Move Condition Evaluator

This combinational unit decides whether a conditional control-flow or data-movement operation takes effect. Decode logic feeds it a condition family (integer flags, floating compare outcome, or a register tested against zero) and a 4-bit condition selector. The unit returns a single taken verdict, used for a branch, a conditional move or a conditional trap. It also returns a squash signal for the delay-slot instruction, which follows the annul-bit rules.

The integer family reads either the low or the high nibble of an 8-bit flag register, so one datapath serves both the 32-bit and the 64-bit flag sets. The floating family picks one of several 2-bit compare-outcome fields by index. The register family tests a signed 64-bit operand against zero. Two selector values, always and never, are shared by every family and carry their own annul rule. Target address arithmetic and register writes happen elsewhere.

Top module: `cond_eval_top`

## Requirements
- R1: `wide_i`=0 takes integer flags from `ccr_i[3:0]` and `wide_i`=1 from `ccr_i[7:4]`; within the nibble bit0 is carry C, bit1 overflow V, bit2 zero Z, bit3 negative N.
- R2: Integer selector codes for signed tests (family 0): 2 greater = !(Z|(N^V)), 3 less-or-equal = Z|(N^V), 4 greater-or-equal = !(N^V), 5 less = N^V.
- R3: Remaining integer codes: 0 not-equal = !Z, 1 equal = Z, 6 unsigned greater = !(C|Z), 7 unsigned less-or-equal = C|Z, 8 carry clear, 9 carry set, 10 positive = !N, 11 negative = N, 12 overflow clear, 13 overflow set.
- R4: In family 1 the compare field is `fcc_i[2k+1:2k]` with k = `fsel_i`; a field value of 00 means equal, 01 less, 10 greater, 11 unordered.
- R5: Floating codes are taken on these outcome sets: 0 {U}, 1 {G}, 2 {U,G}, 3 {L}, 4 {U,L}, 5 {L,G}, 6 {L,G,U}, 7 {E}, 8 {E,U}, 9 {E,G}, 10 {E,G,U}, 11 {E,L}, 12 {E,L,U}, 13 {E,L,G}.
- R6: In family 2, `rval_i` is taken as a signed value compared with zero: code 0 ==0, 1 <=0, 2 <0, 3 !=0, 4 >0, 5 >=0. Codes 6 to 13 are never taken.
- R7: Selector 14 (always) makes `taken_o`=1 and selector 15 (never) makes `taken_o`=0 in every family. For both, `annul_o` equals `annul_i`.
- R8: For selectors 0 to 13, `annul_o` = `annul_i` AND NOT `taken_o`.
- R9: Family 3 is reserved: selectors 0 to 13 are never taken. Inputs belonging to other families (`wide_i` outside family 0, `fsel_i`/`fcc_i` outside family 1, `rval_i` outside family 2) do not change the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ccr_i | input | 8 | Integer flags, low nibble 32-bit set, high nibble 64-bit set |
| fcc_i | input | 2*FCC_FIELDS | Packed floating compare-outcome fields |
| rval_i | input | REG_W | Register operand for tests against zero |
| family_i | input | 2 | 0 integer, 1 floating, 2 register, 3 reserved |
| sel_i | input | 4 | Condition selector, 14 always, 15 never |
| wide_i | input | 1 | Choose the 64-bit integer flag set |
| fsel_i | input | FSEL_W | Index of the floating field |
| annul_i | input | 1 | Annul bit of the instruction |
| taken_o | output | 1 | Condition holds |
| annul_o | output | 1 | Squash the delay-slot instruction |

## Verification
The block holds no state, so a fault in a decode path appears at `taken_o` or `annul_o` as soon as the inputs settle. It appears only for the selector code and family whose logic is wrong; the other codes keep giving correct verdicts. A wrong nibble or field select shows up only when the unselected flags differ from the selected ones. The stimulus therefore loads unequal values into every nibble and field. A swap of the signed and unsigned tests is exposed by operands with the sign bit set and by flag patterns where N differs from V.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

    localparam int SEL_W      = 4;
    localparam int NIB_W      = 4;
    localparam int CCR_W      = 2 * NIB_W;
    localparam int FLD_W      = 2;

    localparam logic [SEL_W-1:0] SEL_ALWAYS = 4'd14;
    localparam logic [SEL_W-1:0] SEL_NEVER  = 4'd15;

    typedef enum logic [1:0] {
        FAM_INT = 2'd0,
        FAM_FLT = 2'd1,
        FAM_REG = 2'd2,
        FAM_RSV = 2'd3
    } fam_e;

    // packed so that bit order matches the flag nibble (N Z V C from msb)
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } iflags_t;

    typedef enum logic [FLD_W-1:0] {
        FC_EQ = 2'b00,
        FC_LT = 2'b01,
        FC_GT = 2'b10,
        FC_UN = 2'b11
    } fcmp_e;

    typedef struct packed {
        logic taken;
        logic annul;
    } verdict_t;

    function automatic logic is_fixed_sel(input logic [SEL_W-1:0] s);
        return (s == SEL_ALWAYS) || (s == SEL_NEVER);
    endfunction

    function automatic logic signed_lt(input iflags_t f);
        return f.n ^ f.v;
    endfunction

endpackage

// File: rtl/int_cond_eval.sv
module int_cond_eval
    import cond_eval_pkg::*;
(
    input  logic [CCR_W-1:0] ccr,
    input  logic             wide,
    input  logic [SEL_W-1:0] sel,
    output logic             hit
);
    iflags_t f;

    assign f = wide ? iflags_t'(ccr[CCR_W-1:NIB_W]) : iflags_t'(ccr[NIB_W-1:0]);

    always_comb begin
        unique case (sel)
            4'd0:    hit = !f.z;
            4'd1:    hit = f.z;
            4'd2:    hit = !(f.z | signed_lt(f));
            4'd3:    hit = f.z | signed_lt(f);
            4'd4:    hit = !signed_lt(f);
            4'd5:    hit = signed_lt(f);
            4'd6:    hit = !(f.c | f.z);
            4'd7:    hit = f.c | f.z;
            4'd8:    hit = !f.c;
            4'd9:    hit = f.c;
            4'd10:   hit = !f.n;
            4'd11:   hit = f.n;
            4'd12:   hit = !f.v;
            4'd13:   hit = f.v;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/fp_cond_eval.sv
module fp_cond_eval
    import cond_eval_pkg::*;
#(
    parameter int FIELDS = 4,
    localparam int FSEL_W = (FIELDS > 1) ? $clog2(FIELDS) : 1
) (
    input  logic [FLD_W*FIELDS-1:0] fcc,
    input  logic [FSEL_W-1:0]       fsel,
    input  logic [SEL_W-1:0]        sel,
    output logic                    hit
);
    logic [FLD_W-1:0] fld [FIELDS];
    fcmp_e            cur;

    for (genvar g = 0; g < FIELDS; g++) begin : g_fld
        assign fld[g] = fcc[FLD_W*g +: FLD_W];
    end

    assign cur = fcmp_e'(fld[fsel]);

    always_comb begin
        unique case (sel)
            4'd0:    hit = (cur == FC_UN);
            4'd1:    hit = (cur == FC_GT);
            4'd2:    hit = cur[1];
            4'd3:    hit = (cur == FC_LT);
            4'd4:    hit = cur[0];
            4'd5:    hit = (cur == FC_LT) || (cur == FC_GT);
            4'd6:    hit = (cur != FC_EQ);
            4'd7:    hit = (cur == FC_EQ);
            4'd8:    hit = (cur == FC_EQ) || (cur == FC_UN);
            4'd9:    hit = !cur[0];
            4'd10:   hit = (cur != FC_LT);
            4'd11:   hit = !cur[1];
            4'd12:   hit = (cur != FC_GT);
            4'd13:   hit = (cur != FC_UN);
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/reg_zero_eval.sv
module reg_zero_eval
    import cond_eval_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0]     val,
    input  logic [SEL_W-1:0] sel,
    output logic             hit
);
    logic neg;
    logic zero;

    assign neg  = val[W-1];
    assign zero = ~|val;

    always_comb begin
        unique case (sel)
            4'd0:    hit = zero;
            4'd1:    hit = zero | neg;
            4'd2:    hit = neg;
            4'd3:    hit = !zero;
            4'd4:    hit = !zero & !neg;
            4'd5:    hit = !neg;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/cond_eval_top.sv
module cond_eval_top
    import cond_eval_pkg::*;
#(
    parameter int REG_W      = 64,
    parameter int FCC_FIELDS = 4,
    localparam int FSEL_W    = (FCC_FIELDS > 1) ? $clog2(FCC_FIELDS) : 1
) (
    input  logic [CCR_W-1:0]            ccr_i,
    input  logic [FLD_W*FCC_FIELDS-1:0] fcc_i,
    input  logic [REG_W-1:0]            rval_i,
    input  logic [1:0]                  family_i,
    input  logic [SEL_W-1:0]            sel_i,
    input  logic                        wide_i,
    input  logic [FSEL_W-1:0]           fsel_i,
    input  logic                        annul_i,
    output logic                        taken_o,
    output logic                        annul_o
);
    logic     int_hit;
    logic     fp_hit;
    logic     reg_hit;
    logic     fam_hit;
    fam_e     fam;
    verdict_t vd;

    assign fam = fam_e'(family_i);

    int_cond_eval u_int (
        .ccr  (ccr_i),
        .wide (wide_i),
        .sel  (sel_i),
        .hit  (int_hit)
    );

    fp_cond_eval #(.FIELDS(FCC_FIELDS)) u_fp (
        .fcc  (fcc_i),
        .fsel (fsel_i),
        .sel  (sel_i),
        .hit  (fp_hit)
    );

    reg_zero_eval #(.W(REG_W)) u_reg (
        .val  (rval_i),
        .sel  (sel_i),
        .hit  (reg_hit)
    );

    always_comb begin
        unique case (fam)
            FAM_INT: fam_hit = int_hit;
            FAM_FLT: fam_hit = fp_hit;
            FAM_REG: fam_hit = reg_hit;
            default: fam_hit = 1'b0;
        endcase
    end

    always_comb begin
        if (is_fixed_sel(sel_i)) begin
            vd.taken = (sel_i == SEL_ALWAYS);
            vd.annul = annul_i;
        end else begin
            vd.taken = fam_hit;
            vd.annul = annul_i & ~fam_hit;
        end
    end

    assign taken_o = vd.taken;
    assign annul_o = vd.annul;

endmodule

// File: rtl/cond_eval_chk.sv
module cond_eval_chk
    import cond_eval_pkg::*;
#(
    parameter int REG_W      = 64,
    parameter int FCC_FIELDS = 4,
    localparam int FSEL_W    = (FCC_FIELDS > 1) ? $clog2(FCC_FIELDS) : 1
) (
    input logic [CCR_W-1:0]            ccr_i,
    input logic [FLD_W*FCC_FIELDS-1:0] fcc_i,
    input logic [REG_W-1:0]            rval_i,
    input logic [1:0]                  family_i,
    input logic [SEL_W-1:0]            sel_i,
    input logic                        wide_i,
    input logic [FSEL_W-1:0]           fsel_i,
    input logic                        annul_i,
    input logic                        taken_o,
    input logic                        annul_o
);
    logic [FLD_W-1:0] pick;
    assign pick = fcc_i[FLD_W*fsel_i +: FLD_W];

    always_comb begin
        // R7
        always_taken_chk: assert (sel_i != SEL_ALWAYS || taken_o);
        // R7
        never_taken_chk: assert (sel_i != SEL_NEVER || !taken_o);
        // R8
        annul_needs_bit_chk: assert (!annul_o || annul_i);
        // R8
        cond_annul_excl_chk: assert (is_fixed_sel(sel_i) || !(annul_o && taken_o));
        // R9
        reserved_family_chk: assert (family_i != 2'd3 || is_fixed_sel(sel_i) || !taken_o);
        // R6
        reg_reserved_code_chk: assert (!(family_i == 2'd2 && sel_i >= 4'd6 && sel_i <= 4'd13) || !taken_o);
        // R5
        fp_ordered_chk: assert (!(family_i == 2'd1 && sel_i == 4'd13) || (taken_o == (pick != 2'b11)));
    end
endmodule

bind cond_eval_top cond_eval_chk #(.REG_W(REG_W), .FCC_FIELDS(FCC_FIELDS)) chk_i (
    .ccr_i    (ccr_i),
    .fcc_i    (fcc_i),
    .rval_i   (rval_i),
    .family_i (family_i),
    .sel_i    (sel_i),
    .wide_i   (wide_i),
    .fsel_i   (fsel_i),
    .annul_i  (annul_i),
    .taken_o  (taken_o),
    .annul_o  (annul_o)
);

// File: tb/cond_eval_top_tb_top.sv
module cond_eval_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int REG_W      = 64;
    localparam int FIELDS     = 4;
    localparam int NRAND      = 3000;

    logic                clk = 1'b0;
    logic [7:0]          ccr_i = '0;
    logic [2*FIELDS-1:0] fcc_i = '0;
    logic [REG_W-1:0]    rval_i = '0;
    logic [1:0]          family_i = '0;
    logic [3:0]          sel_i = '0;
    logic                wide_i = 1'b0;
    logic [1:0]          fsel_i = '0;
    logic                annul_i = 1'b0;
    logic                taken_o;
    logic                annul_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cond_eval_top #(.REG_W(REG_W), .FCC_FIELDS(FIELDS)) dut_i (
        .ccr_i(ccr_i), .fcc_i(fcc_i), .rval_i(rval_i), .family_i(family_i),
        .sel_i(sel_i), .wide_i(wide_i), .fsel_i(fsel_i), .annul_i(annul_i),
        .taken_o(taken_o), .annul_o(annul_o)
    );

    function automatic bit m_int(input logic [7:0] cc, input bit w, input int s);
        bit c, v, z, n;
        logic [3:0] nb;
        nb = w ? cc[7:4] : cc[3:0];
        c = nb[0]; v = nb[1]; z = nb[2]; n = nb[3];
        case (s)
            0: return !z;          1: return z;
            2: return !z && (n == v); 3: return z || (n != v);
            4: return n == v;      5: return n != v;
            6: return !c && !z;    7: return c || z;
            8: return !c;          9: return c;
            10: return !n;         11: return n;
            12: return !v;         13: return v;
            default: return 0;
        endcase
    endfunction

    function automatic bit m_flt(input logic [2*FIELDS-1:0] fc, input int k, input int s);
        logic [3:0] mask; // bit index = outcome: 0 E, 1 L, 2 G, 3 U
        int o;
        o = (fc >> (2*k)) & 3;
        case (s)
            0: mask = 4'b1000;  1: mask = 4'b0100;  2: mask = 4'b1100;
            3: mask = 4'b0010;  4: mask = 4'b1010;  5: mask = 4'b0110;
            6: mask = 4'b1110;  7: mask = 4'b0001;  8: mask = 4'b1001;
            9: mask = 4'b0101;  10: mask = 4'b1101; 11: mask = 4'b0011;
            12: mask = 4'b1011; 13: mask = 4'b0111;
            default: mask = 4'b0000;
        endcase
        return mask[o];
    endfunction

    function automatic bit m_reg(input logic [REG_W-1:0] r, input int s);
        longint sv;
        sv = longint'(r);
        case (s)
            0: return sv == 0;  1: return sv <= 0;  2: return sv < 0;
            3: return sv != 0;  4: return sv > 0;   5: return sv >= 0;
            default: return 0;
        endcase
    endfunction

    task automatic apply(input int fam, input int s, input logic [7:0] cc,
                         input logic [2*FIELDS-1:0] fc, input logic [REG_W-1:0] r,
                         input bit w, input int k, input bit a);
        @(posedge clk);
        family_i = 2'(fam); sel_i = 4'(s); ccr_i = cc; fcc_i = fc;
        rval_i = r; wide_i = w; fsel_i = 2'(k); annul_i = a;
        @(negedge clk);
    endtask

    task automatic check(input string req, input bit et, input bit ea);
        n_chk++;
        if (taken_o !== et || annul_o !== ea) begin
            n_bad++;
            $display("FAIL %s fam=%0d sel=%0d: taken/annul actual %b%b expected %b%b",
                     req, family_i, sel_i, taken_o, annul_o, et, ea);
        end
    endtask

    function automatic bit exp_t(input int fam, input int s, input logic [7:0] cc,
                                 input logic [2*FIELDS-1:0] fc, input logic [REG_W-1:0] r,
                                 input bit w, input int k);
        if (s == 14) return 1;
        if (s == 15) return 0;
        case (fam)
            0: return m_int(cc, w, s);
            1: return m_flt(fc, k, s);
            2: return m_reg(r, s);
            default: return 0;
        endcase
    endfunction

    task automatic run(input string req, input int fam, input int s, input logic [7:0] cc,
                       input logic [2*FIELDS-1:0] fc, input logic [REG_W-1:0] r,
                       input bit w, input int k, input bit a);
        bit t, an;
        apply(fam, s, cc, fc, r, w, k, a);
        t  = exp_t(fam, s, cc, fc, r, w, k);
        an = (s >= 14) ? a : (a && !t);
        check(req, t, an);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        // all-zero inputs: integer not-equal with Z clear is taken, no annul (R3)
        @(negedge clk);
        check("R3 idle", 1'b1, 1'b0);

        // R1: nibble select, low Z=1 high Z=0
        run("R1 low nibble", 0, 1, 8'h04, '0, '0, 0, 0, 0);
        run("R1 high nibble", 0, 1, 8'h04, '0, '0, 1, 0, 0);
        run("R1 high Z", 0, 1, 8'h40, '0, '0, 1, 0, 0);
        // R2: N!=V gives less
        run("R2 less", 0, 5, 8'h08, '0, '0, 0, 0, 0);
        run("R2 greater", 0, 2, 8'h0A, '0, '0, 0, 0, 0);
        // R3: unsigned less-or-equal via carry
        run("R3 leu", 0, 7, 8'h01, '0, '0, 0, 0, 1);
        // R4/R5: field 2 unordered, others equal
        run("R4 field2 unord", 1, 0, '0, 8'b00_11_00_00, '0, 0, 2, 0);
        run("R4 field1 eq", 1, 0, '0, 8'b00_11_00_00, '0, 0, 1, 0);
        run("R5 ordered on unord", 1, 13, '0, 8'b11_00_00_00, '0, 0, 3, 1);
        run("R5 ug on greater", 1, 2, '0, 8'b00_00_10_00, '0, 0, 1, 0);
        // R6: sign bit and reserved codes
        run("R6 lz min", 2, 2, '0, '0, 64'h8000_0000_0000_0000, 0, 0, 0);
        run("R6 gz min", 2, 4, '0, '0, 64'h8000_0000_0000_0000, 0, 0, 1);
        run("R6 z zero", 2, 0, '0, '0, '0, 0, 0, 0);
        run("R6 reserved code", 2, 9, '0, '0, '0, 0, 0, 1);
        // R7: always/never with annul
        run("R7 always annul", 0, 14, '0, '0, '0, 0, 0, 1);
        run("R7 never annul", 2, 15, '0, '0, '0, 0, 0, 1);
        run("R7 always rsv fam", 3, 14, '0, '0, '0, 0, 0, 0);
        // R8: conditional taken with annul bit set -> no annul
        run("R8 taken no annul", 0, 9, 8'h01, '0, '0, 0, 0, 1);
        // R9: reserved family, and ignored foreign inputs
        run("R9 rsv fam", 3, 8, 8'hFF, '1, '1, 1, 3, 1);
        run("R9 wide ignored in reg", 2, 0, 8'h0F, '1, '0, 1, 3, 0);

        for (int i = 0; i < NRAND; i++) begin
            int fam, s, k;
            logic [REG_W-1:0] r;
            fam = $urandom_range(0, 3);
            s   = $urandom_range(0, 15);
            k   = $urandom_range(0, 3);
            r   = {$urandom(), $urandom()};
            if ($urandom_range(0, 7) == 0) r = '0;
            run(fam == 0 ? "R2 R3 rand" : fam == 1 ? "R5 rand" :
                fam == 2 ? "R6 rand" : "R9 rand",
                fam, s, 8'($urandom()), 8'($urandom()), r,
                1'($urandom()), k, 1'($urandom()));
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule